// File: doc/BRIEF.md
# Bidirectional Flyback Gate-Steering PWM Core

This block is the digital heart of a four-quadrant flyback ring-signal generator. A free-running triangular up/down counter serves as the PWM ramp. A digital error magnitude, supplied from outside, is compared against that ramp only while it counts down. This is leading-edge modulation: a pulse begins when the ramp drops below the magnitude, and it ends when the ramp reaches its bottom. The duty cycle therefore cannot exceed one half.

The polarity of the reference and the sign of the error together select one of four operating modes. The mode decides which of three gate outputs carries the PWM pulse, which output acts as a synchronous rectifier on the rising slope, and which outputs stay off. The three gate outputs are one primary switch and two secondary switches, one n-channel and one p-channel. The p-channel drive is active low.

A cycle-by-cycle current-limit input suppresses the pulse for the rest of the falling slope. An enable input parks every switch off. A range flag reports whether the demanded duty lies strictly inside the usable span.

Top module: `fqf_ring_pwm`

## Requirements
- R1: After reset the ramp counter starts at 0 and counts upward. It rises one step per clock to the maximum (255 for 8 bits), then falls one step per clock back to 0, and then turns upward again. One full period is therefore 510 clocks.
- R2: A PWM pulse is active in a cycle only when the ramp is on its falling slope and the counter value is below `err_mag`. No pulse ever occurs on the rising slope. With `err_mag` = 0 there is no pulse at all, and with `err_mag` = 255 the pulse covers the whole falling slope.
- R3: The mode code {`ref_neg`,`err_sign`} is captured only in the cycle in which the ramp sits at its peak while rising. It takes effect from the next cycle and is held until the next peak. Changes at any other time have no effect on the outputs.
- R4: Mode code 00 (reference positive, error sign 0): `gd1_pri` carries the pulse, `gd2_sec_n` is driven low during the whole rising slope as the rectifier, and `gd3_sec` stays low.
- R5: Mode code 01 (reference positive, error sign 1): `gd3_sec` carries the pulse, `gd1_pri` stays low and `gd2_sec_n` stays high.
- R6: Mode code 10 (reference negative, error sign 0): `gd1_pri` carries the pulse, `gd3_sec` is high during the whole rising slope as the rectifier, and `gd2_sec_n` stays high.
- R7: Mode code 11 (reference negative, error sign 1): `gd2_sec_n` carries the pulse, active low, while `gd1_pri` and `gd3_sec` stay low.
- R8: `gd2_sec_n` is active low. In every off state it is 1, while the other two gates are 0 in their off states.
- R9: While the ramp falls, `dc_limit` high in any cycle blocks the pulse in that cycle and in every remaining cycle of that falling slope, including the bottom cycle. The block is released when the ramp turns upward. On the rising slope `dc_limit` has no effect.
- R10: With `enable` low, `gd1_pri` = 0, `gd3_sec` = 0 and `gd2_sec_n` = 1, whatever the mode, ramp or limit state. The ramp and mode capture keep running.
- R11: `range_ok` is 1 exactly when `err_mag` is neither 0 nor 255, that is, when the demanded duty is strictly between 0 and one half.
- R12: While `rst_n` is low, the ramp is held at 0 rising, the mode code is 00 and the limit block is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ramp clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High allows switching; low parks all gates off |
| ref_neg | input | 1 | Reference polarity, 1 = negative |
| err_sign | input | 1 | Error sign, 1 = power returned to input |
| err_mag | input | 8 | Error magnitude compared with the ramp |
| dc_limit | input | 1 | Current-limit trip, cycle-by-cycle |
| gd1_pri | output | 1 | Primary switch drive, active high |
| gd2_sec_n | output | 1 | p-channel secondary drive, active low |
| gd3_sec | output | 1 | n-channel secondary drive, active high |
| range_ok | output | 1 | Demanded duty strictly inside (0, 0.5) |

## Verification
The bench goes after the ramp turning points. A counter that dwells an extra cycle at the peak or the bottom, or that wraps instead of reversing, shifts every later pulse and is flagged within one period. It changes the mode inputs in the middle of a slope. A design that decodes the mode live would cut or move pulses in the middle of the falling slope instead of waiting for the peak.

The bench also gives the current limit one-cycle trips at scattered points, including on the rising slope. A non-latching limit would let the pulse resume within the same falling slope. A limit that never clears would block the following period. Finally, the bench runs `err_mag` at 0 and 255, where an off-by-one compare either emits a stray pulse or loses the bottom cycle.

// File: rtl/fqf_pkg.sv
package fqf_pkg;

    // Mode code is {reference negative, error sign}
    typedef enum logic [1:0] {
        MODE_FWD_POS = 2'b00,
        MODE_REV_POS = 2'b01,
        MODE_FWD_NEG = 2'b10,
        MODE_REV_NEG = 2'b11
    } fqf_mode_e;

    typedef struct packed {
        logic pri;      // primary switch, active high
        logic pch_n;    // p-channel secondary, active low
        logic nch;      // n-channel secondary, active high
    } fqf_gate_t;

    localparam fqf_gate_t GATES_OFF = '{pri: 1'b0, pch_n: 1'b1, nch: 1'b0};

endpackage

// File: rtl/fqf_ramp.sv
module fqf_ramp #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count,
    output logic             falling,
    output logic             at_peak,
    output logic             at_bottom
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fall;
    } ramp_st_t;

    ramp_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        at_peak   = !st_q.fall && (st_q.cnt == TOP);
        at_bottom =  st_q.fall && (st_q.cnt == '0);
        if (at_peak) begin
            st_d.fall = 1'b1;
            st_d.cnt  = TOP - 1'b1;
        end else if (at_bottom) begin
            st_d.fall = 1'b0;
            st_d.cnt  = {{(CNT_W-1){1'b0}}, 1'b1};
        end else if (st_q.fall) begin
            st_d.cnt  = st_q.cnt - 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign falling = st_q.fall;

    AST_RAMP_RISE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!falling && count != TOP) |=> (!falling && count == CNT_W'($past(count) + 1'b1))); // R1
    AST_RAMP_FALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (falling && count != '0) |=> (falling && count == CNT_W'($past(count) - 1'b1))); // R1
    AST_RAMP_REVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        at_peak |=> (falling && count == TOP - 1'b1)); // R1

endmodule

// File: rtl/fqf_ctrl.sv
module fqf_ctrl
    import fqf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      at_peak,
    input  logic      at_bottom,
    input  logic      falling,
    input  logic      ref_neg,
    input  logic      err_sign,
    input  logic      dc_limit,
    output fqf_mode_e mode,
    output logic      blocked
);
    typedef struct packed {
        fqf_mode_e mode;
        logic      lim;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // capture the mode only at the ramp peak, never inside a pulse
        if (at_peak) begin
            st_d.mode = fqf_mode_e'({ref_neg, err_sign});
        end
        // limit latch lives for one falling slope
        if (falling && !at_bottom) begin
            st_d.lim = st_q.lim | dc_limit;
        end else begin
            st_d.lim = 1'b0;
        end
        blocked = falling && (st_q.lim || dc_limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_FWD_POS, lim: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !at_peak |=> $stable(mode)); // R3
    AST_LIM_RISE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !falling |-> !st_q.lim); // R9
    AST_LIM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !at_bottom) |=> blocked); // R9

endmodule

// File: rtl/fqf_steer.sv
module fqf_steer
    import fqf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic             falling,
    input  logic [CNT_W-1:0] err_mag,
    input  logic             blocked,
    input  logic             enable,
    input  fqf_mode_e        mode,
    output fqf_gate_t        gates
);
    logic pulse;
    logic rectify;

    always_comb begin
        pulse   = falling && (count < err_mag) && !blocked;
        rectify = !falling;
        gates   = GATES_OFF;
        if (enable) begin
            unique case (mode)
                MODE_FWD_POS: begin
                    gates.pri   = pulse;
                    gates.pch_n = !rectify;
                end
                MODE_REV_POS: begin
                    gates.nch   = pulse;
                end
                MODE_FWD_NEG: begin
                    gates.pri   = pulse;
                    gates.nch   = rectify;
                end
                MODE_REV_NEG: begin
                    gates.pch_n = !pulse;
                end
                default: gates = GATES_OFF;
            endcase
        end
    end

endmodule

// File: rtl/fqf_ring_pwm.sv
module fqf_ring_pwm
    import fqf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ref_neg,
    input  logic             err_sign,
    input  logic [CNT_W-1:0] err_mag,
    input  logic             dc_limit,
    output logic             gd1_pri,
    output logic             gd2_sec_n,
    output logic             gd3_sec,
    output logic             range_ok
);
    localparam logic [CNT_W-1:0] MAG_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] ramp_cnt;
    logic             ramp_fall;
    logic             ramp_peak;
    logic             ramp_bottom;
    fqf_mode_e        cur_mode;
    logic             lim_block;
    fqf_gate_t        gate_drv;

    fqf_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (ramp_cnt),
        .falling   (ramp_fall),
        .at_peak   (ramp_peak),
        .at_bottom (ramp_bottom)
    );

    fqf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .at_peak   (ramp_peak),
        .at_bottom (ramp_bottom),
        .falling   (ramp_fall),
        .ref_neg   (ref_neg),
        .err_sign  (err_sign),
        .dc_limit  (dc_limit),
        .mode      (cur_mode),
        .blocked   (lim_block)
    );

    fqf_steer #(.CNT_W(CNT_W)) u_steer (
        .count   (ramp_cnt),
        .falling (ramp_fall),
        .err_mag (err_mag),
        .blocked (lim_block),
        .enable  (enable),
        .mode    (cur_mode),
        .gates   (gate_drv)
    );

    always_comb begin
        gd1_pri   = gate_drv.pri;
        gd2_sec_n = gate_drv.pch_n;
        gd3_sec   = gate_drv.nch;
        range_ok  = (err_mag != '0) && (err_mag != MAG_TOP);
    end

    AST_PRI_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !ramp_fall |-> !gd1_pri); // R2
    AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(gd1_pri && gd3_sec)); // R6
    AST_DISABLED_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!gd1_pri && gd2_sec_n && !gd3_sec)); // R10
    AST_LIMIT_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        lim_block |-> (!gd1_pri && gd2_sec_n && !gd3_sec)); // R9
    AST_ZERO_MAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mag == '0) |-> !gd1_pri); // R2

endmodule

// File: tb/fqf_ring_pwm_bench.sv
`timescale 1ns/1ps
module fqf_ring_pwm_bench;
    localparam int W    = 8;
    localparam int TOPV = 255;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         enable;
    logic         ref_neg;
    logic         err_sign;
    logic [W-1:0] err_mag;
    logic         dc_limit;
    logic         gd1_pri;
    logic         gd2_sec_n;
    logic         gd3_sec;
    logic         range_ok;

    always #2.5 clk = ~clk;

    fqf_ring_pwm #(.CNT_W(W)) u_fqf_ring_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .ref_neg   (ref_neg),
        .err_sign  (err_sign),
        .err_mag   (err_mag),
        .dc_limit  (dc_limit),
        .gd1_pri   (gd1_pri),
        .gd2_sec_n (gd2_sec_n),
        .gd3_sec   (gd3_sec),
        .range_ok  (range_ok)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string tag      = "R12";

    // behavioural model state
    int       m_cnt  = 0;
    bit       m_up   = 1'b1;
    bit [1:0] m_mode = 2'b00;
    bit       m_lim  = 1'b0;

    task automatic check(string name, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b (cnt=%0d up=%0b mode=%0d)",
                     tag, name, $time, act, exp, m_cnt, m_up, m_mode);
        end
    endtask

    task automatic compare();
        bit pulse, rect, e1, e2n, e3, rok;
        pulse = !m_up && (m_cnt < int'(err_mag)) && !(m_lim || dc_limit);
        rect  = m_up;
        e1 = 1'b0; e2n = 1'b1; e3 = 1'b0;
        if (enable) begin
            case (m_mode)
                2'b00: begin e1 = pulse; e2n = !rect; end   // R4
                2'b01: begin e3 = pulse; end                // R5
                2'b10: begin e1 = pulse; e3 = rect; end     // R6
                default: begin e2n = !pulse; end            // R7, R8
            endcase
        end
        rok = (err_mag != 0) && (err_mag != TOPV);          // R11
        check("gd1_pri",   gd1_pri,   e1);
        check("gd2_sec_n", gd2_sec_n, e2n);
        check("gd3_sec",   gd3_sec,   e3);
        check("range_ok",  range_ok,  rok);
    endtask

    task automatic step();
        bit nlim;
        #1;
        compare();
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = 0; m_up = 1'b1; m_mode = 2'b00; m_lim = 1'b0;   // R12
        end else begin
            nlim = (!m_up && m_cnt != 0) ? (m_lim || dc_limit) : 1'b0;  // R9
            if (m_up) begin
                if (m_cnt == TOPV) begin
                    m_mode = {ref_neg, err_sign};                   // R3
                    m_up   = 1'b0;
                    m_cnt  = TOPV - 1;
                end else begin
                    m_cnt++;
                end
            end else begin
                if (m_cnt == 0) begin
                    m_up  = 1'b1;
                    m_cnt = 1;
                end else begin
                    m_cnt--;
                end
            end
            m_lim = nlim;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; ref_neg = 1'b1; err_sign = 1'b1;
        err_mag = 8'd100; dc_limit = 1'b0;
        @(negedge clk);
        // R12: reset state, mode inputs ignored while in reset
        tag = "R12";
        for (int i = 0; i < 6; i++) step();
        rst_n = 1'b1;
        ref_neg = 1'b0; err_sign = 1'b0;

        // R1 R4: full periods in forward positive mode
        tag = "R1 R4";
        for (int i = 0; i < 1100; i++) step();

        // R2 R11: sweep magnitude, then both extremes
        tag = "R2 R11";
        for (int i = 0; i < 1020; i++) begin
            err_mag = W'((i * 7) % 256);
            step();
        end
        err_mag = 8'd0;
        for (int i = 0; i < 520; i++) step();
        err_mag = 8'd255;
        for (int i = 0; i < 520; i++) step();
        err_mag = 8'd1;
        for (int i = 0; i < 520; i++) step();

        err_mag = 8'd150;
        tag = "R5";
        ref_neg = 1'b0; err_sign = 1'b1;
        for (int i = 0; i < 1100; i++) step();
        tag = "R6";
        ref_neg = 1'b1; err_sign = 1'b0;
        for (int i = 0; i < 1100; i++) step();
        tag = "R7 R8";
        ref_neg = 1'b1; err_sign = 1'b1;
        for (int i = 0; i < 1100; i++) step();

        // R3: mode inputs toggled in mid-slope
        tag = "R3";
        for (int i = 0; i < 1600; i++) begin
            {ref_neg, err_sign} = 2'((i / 37) % 4);
            step();
        end

        // R9: short limit trips scattered over both slopes
        tag = "R9";
        ref_neg = 1'b0; err_sign = 1'b0; err_mag = 8'd200;
        for (int i = 0; i < 1600; i++) begin
            dc_limit = ((i % 97) < 2) || (i % 211 == 3);
            step();
        end
        ref_neg = 1'b1; err_sign = 1'b1;
        for (int i = 0; i < 1100; i++) begin
            dc_limit = (i % 131 == 7);
            step();
        end
        dc_limit = 1'b0;

        // R10: enable toggled across modes
        tag = "R10";
        for (int i = 0; i < 2100; i++) begin
            enable = (i % 300) < 150;
            {ref_neg, err_sign} = 2'((i / 510) % 4);
            step();
        end
        enable = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule